// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block produces the active-low read and write strobes for parallel ATA programmed-I/O and multiword-DMA data cycles, and for task-file register cycles, across a small set of device slots. Each slot holds one packed 32-bit timing word. For each kind of cycle, the word sets three durations: a setup delay before the first cycle, the time the strobe is held low, and the time the strobe is held high afterwards. Command (task-file) cycles and data cycles take their durations from separate fields of the same word.

Timing words are loaded through a configuration write port. A write either replaces the whole word or merges new bits under a fixed mask that belongs to one transfer-mode class, and leaves every other bit as it was. A controller raises a cycle request that names a channel and device and says whether the cycle is a command or data cycle, and whether it reads or writes. The block then runs the cycle and ends it with a one-clock done pulse. A further request of the same kind that is present in the done cycle runs back to back, with no setup delay.

Top module: `ata_strobe_gen`

## Requirements
- R1: After reset both strobes are high, the done pulse is low and every slot's timing word reads back as zero.
- R2: The slot of a channel/device pair is device + DEVS_PER_CHAN × channel. A configuration write changes only the addressed slot. The addressed word reads back on cfg_rdata from the clock after the writing edge.
- R3: The cfg_upd code picks the merge mask: 0 writes all 32 bits, 1 (PIO) uses mask 0xCFC3FFFF, 2 (multiword DMA) uses 0x31C001FF, and 3 (UDMA) uses 0x303C0000. Bits under the mask take the new value and all other bits keep the stored value.
- R4: A data cycle uses bits 24:22 as setup, bits 8:4 as strobe-low time and bits 3:0 as strobe-high time. Each phase lasts the field value plus one clocks.
- R5: A command cycle uses bits 27:25 as setup, bits 17:13 as strobe-low time and bits 12:9 as strobe-high time. Each phase lasts the field value plus one clocks.
- R6: A read cycle lowers only dior_n and a write cycle lowers only diow_n. The two strobes are never low together.
- R7: cyc_done is high for exactly one clock, the last clock of the strobe-high phase, and both strobes are high while it is.
- R8: A request is accepted when the block is idle, and the first clock after acceptance is setup. A request is also accepted in the done clock. Requests in any other busy clock are ignored.
- R9: A request accepted in the done clock of a cycle of the same kind (command or data) skips setup and lowers its strobe in the next clock. A request of the other kind goes through setup.
- R10: A timing word does not change unless cfg_we is high.
- R11: The durations are taken from the slot's word at acceptance. A configuration write during the cycle does not change that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_chan | input | CHAN_W (1) | Channel of the configured slot |
| cfg_dev | input | DEV_W (1) | Device of the configured slot |
| cfg_upd | input | 2 | Merge-mask class code |
| cfg_wdata | input | 32 | New timing word |
| cfg_rdata | output | 32 | Stored word of the slot at cfg_chan/cfg_dev |
| req_valid | input | 1 | Cycle request |
| req_chan | input | CHAN_W (1) | Channel of the requested cycle |
| req_dev | input | DEV_W (1) | Device of the requested cycle |
| req_cmd | input | 1 | 1 = task-file cycle, 0 = data cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| cyc_done | output | 1 | One-clock end-of-cycle pulse |

## Verification
A configuration write is visible on cfg_rdata in the clock after the writing edge. The bench therefore reads back one falling edge after it drops cfg_we. After a request is accepted at a rising edge, the setup phase is the first thing seen at the next falling edge. The bench samples the strobes and done at every falling edge and counts the setup, low and high clocks against the field value plus one. For back-to-back cycles, the next request is driven at the falling edge where done is seen, so it is present at the done-cycle rising edge. At the following falling edge the strobe must already be low (same kind) or still high (other kind).

// File: rtl/ata_strobe_pkg.sv
`timescale 1ns/1ps
package ata_strobe_pkg;

    localparam int WORD_W  = 32;
    localparam int INACT_W = 4;
    localparam int ACT_W   = 5;
    localparam int SETUP_W = 3;
    localparam int CNT_W   = ACT_W;

    // field positions inside a timing word
    localparam int D_INACT_LSB = 0;
    localparam int D_ACT_LSB   = 4;
    localparam int C_INACT_LSB = 9;
    localparam int C_ACT_LSB   = 13;
    localparam int D_SETUP_LSB = 22;
    localparam int C_SETUP_LSB = 25;

    localparam logic [WORD_W-1:0] MASK_FULL  = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] MASK_PIO   = 32'hCFC3_FFFF;
    localparam logic [WORD_W-1:0] MASK_MWDMA = 32'h31C0_01FF;
    localparam logic [WORD_W-1:0] MASK_UDMA  = 32'h303C_0000;

    typedef enum logic [1:0] {
        UPD_FULL  = 2'd0,
        UPD_PIO   = 2'd1,
        UPD_MWDMA = 2'd2,
        UPD_UDMA  = 2'd3
    } upd_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_RECOVER
    } phase_e;

    typedef struct packed {
        logic [SETUP_W-1:0] setup;
        logic [ACT_W-1:0]   act;
        logic [INACT_W-1:0] inact;
    } span_t;

    function automatic logic [WORD_W-1:0] upd_mask(upd_e k);
        logic [WORD_W-1:0] m;
        unique case (k)
            UPD_PIO:   m = MASK_PIO;
            UPD_MWDMA: m = MASK_MWDMA;
            UPD_UDMA:  m = MASK_UDMA;
            default:   m = MASK_FULL;
        endcase
        return m;
    endfunction

    function automatic span_t pick_span(logic [WORD_W-1:0] w, logic is_cmd);
        span_t s;
        if (is_cmd) begin
            s.inact = w[C_INACT_LSB +: INACT_W];
            s.act   = w[C_ACT_LSB +: ACT_W];
            s.setup = w[C_SETUP_LSB +: SETUP_W];
        end else begin
            s.inact = w[D_INACT_LSB +: INACT_W];
            s.act   = w[D_ACT_LSB +: ACT_W];
            s.setup = w[D_SETUP_LSB +: SETUP_W];
        end
        return s;
    endfunction

endpackage

// File: rtl/ata_slot_index.sv
`timescale 1ns/1ps
module ata_slot_index #(
    parameter int DEVS_PER_CHAN = 2,
    parameter int CHAN_W        = 1,
    parameter int DEV_W         = 1,
    parameter int SLOT_W        = 2
) (
    input  logic [CHAN_W-1:0] chan,
    input  logic [DEV_W-1:0]  dev,
    output logic [SLOT_W-1:0] idx
);
    // slot = device + devices-per-channel * channel
    assign idx = SLOT_W'(chan) * SLOT_W'(DEVS_PER_CHAN) + SLOT_W'(dev);
endmodule

// File: rtl/ata_timing_bank.sv
`timescale 1ns/1ps
module ata_timing_bank
    import ata_strobe_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_idx,
    input  upd_e              wr_kind,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_a_idx,
    output logic [WORD_W-1:0] rd_a_data,
    input  logic [SLOT_W-1:0] rd_b_idx,
    input  logic              rd_b_cmd,
    output span_t             rd_b_span
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0][WORD_W-1:0] word;
    } bank_t;

    bank_t                 bank_d, bank_q;
    logic [NUM_SLOTS-1:0]  hit;
    logic [WORD_W-1:0]     wmask;
    logic [WORD_W-1:0]     rd_b_word;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hit
        assign hit[g] = wr_en && (wr_idx == SLOT_W'(g));
    end

    always_comb begin
        bank_d = bank_q;
        wmask  = upd_mask(wr_kind);
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (hit[k]) begin
                bank_d.word[k] = (bank_q.word[k] & ~wmask) | (wr_data & wmask);
            end
        end
        rd_a_data = (int'(rd_a_idx) < NUM_SLOTS) ? bank_q.word[rd_a_idx] : '0;
        rd_b_word = (int'(rd_b_idx) < NUM_SLOTS) ? bank_q.word[rd_b_idx] : '0;
        rd_b_span = pick_span(rd_b_word, rd_b_cmd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_q)); // R10
    AST_BANK_KEEP_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((bank_q.word[$past(wr_idx)] ^ $past(bank_q.word[wr_idx])) & ~$past(wmask)) == '0)); // R3
    AST_BANK_TAKE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((bank_q.word[$past(wr_idx)] ^ $past(wr_data)) & $past(wmask)) == '0)); // R3
endmodule

// File: rtl/ata_strobe_seq.sv
`timescale 1ns/1ps
module ata_strobe_seq
    import ata_strobe_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req_valid,
    input  logic  req_cmd,
    input  logic  req_write,
    input  span_t req_span,
    output logic  dior_n,
    output logic  diow_n,
    output logic  done
);
    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic               is_cmd;
        logic               is_wr;
        logic [ACT_W-1:0]   act_len;
        logic [INACT_W-1:0] inact_len;
    } seq_t;

    localparam seq_t SEQ_RST = '{ph: PH_IDLE, cnt: '0, is_cmd: 1'b0, is_wr: 1'b0,
                                 act_len: '0, inact_len: '0};

    seq_t s_d, s_q;
    logic done_w;
    logic take;

    always_comb begin
        s_d    = s_q;
        done_w = (s_q.ph == PH_RECOVER) && (s_q.cnt == '0);
        take   = req_valid && ((s_q.ph == PH_IDLE) || done_w);

        unique case (s_q.ph)
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_ACTIVE;
                    s_d.cnt = CNT_W'(s_q.act_len);
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            PH_ACTIVE: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_RECOVER;
                    s_d.cnt = CNT_W'(s_q.inact_len);
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            PH_RECOVER: begin
                if (s_q.cnt == '0) begin
                    s_d.ph = PH_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            default: begin
            end
        endcase

        if (take) begin
            s_d.is_cmd    = req_cmd;
            s_d.is_wr     = req_write;
            s_d.act_len   = req_span.act;
            s_d.inact_len = req_span.inact;
            if (done_w && (req_cmd == s_q.is_cmd)) begin
                s_d.ph  = PH_ACTIVE;
                s_d.cnt = CNT_W'(req_span.act);
            end else begin
                s_d.ph  = PH_SETUP;
                s_d.cnt = CNT_W'(req_span.setup);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SEQ_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign dior_n = !((s_q.ph == PH_ACTIVE) && !s_q.is_wr);
    assign diow_n = !((s_q.ph == PH_ACTIVE) && s_q.is_wr);
    assign done   = done_w;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dior_n && diow_n)); // R7
    AST_IDLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.ph == PH_IDLE) && req_valid) |=> (s_q.ph == PH_SETUP)); // R8
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.ph != PH_IDLE) && !done) |=> ($stable(s_q.is_wr) && $stable(s_q.is_cmd))); // R8
    AST_B2B_NO_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req_valid && (req_cmd == s_q.is_cmd)) |=> (!dior_n || !diow_n)); // R9
    AST_KIND_CHANGE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req_valid && (req_cmd != s_q.is_cmd)) |=> (dior_n && diow_n && !done)); // R9
endmodule

// File: rtl/ata_strobe_gen.sv
`timescale 1ns/1ps
module ata_strobe_gen
    import ata_strobe_pkg::*;
#(
    parameter int NUM_CHAN      = 2,
    parameter int DEVS_PER_CHAN = 2,
    localparam int NUM_SLOTS = NUM_CHAN * DEVS_PER_CHAN,
    localparam int CHAN_W    = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
    localparam int DEV_W     = (DEVS_PER_CHAN > 1) ? $clog2(DEVS_PER_CHAN) : 1,
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic [DEV_W-1:0]  cfg_dev,
    input  logic [1:0]        cfg_upd,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic              req_cmd,
    input  logic              req_write,
    output logic              dior_n,
    output logic              diow_n,
    output logic              cyc_done
);
    logic [SLOT_W-1:0] cfg_idx;
    logic [SLOT_W-1:0] req_idx;
    span_t             req_span;

    ata_slot_index #(
        .DEVS_PER_CHAN(DEVS_PER_CHAN), .CHAN_W(CHAN_W), .DEV_W(DEV_W), .SLOT_W(SLOT_W)
    ) u_cfg_idx (
        .chan(cfg_chan), .dev(cfg_dev), .idx(cfg_idx)
    );

    ata_slot_index #(
        .DEVS_PER_CHAN(DEVS_PER_CHAN), .CHAN_W(CHAN_W), .DEV_W(DEV_W), .SLOT_W(SLOT_W)
    ) u_req_idx (
        .chan(req_chan), .dev(req_dev), .idx(req_idx)
    );

    ata_timing_bank #(
        .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_kind   (upd_e'(cfg_upd)),
        .wr_data   (cfg_wdata),
        .rd_a_idx  (cfg_idx),
        .rd_a_data (cfg_rdata),
        .rd_b_idx  (req_idx),
        .rd_b_cmd  (req_cmd),
        .rd_b_span (req_span)
    );

    ata_strobe_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_cmd   (req_cmd),
        .req_write (req_write),
        .req_span  (req_span),
        .dior_n    (dior_n),
        .diow_n    (diow_n),
        .done      (cyc_done)
    );
endmodule

// File: tb/tb_ata_strobe_gen.sv
`timescale 1ns/1ps
module tb_ata_strobe_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_chan = '0;
    logic [0:0]  cfg_dev = '0;
    logic [1:0]  cfg_upd = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [0:0]  req_chan = '0;
    logic [0:0]  req_dev = '0;
    logic        req_cmd = 1'b0;
    logic        req_write = 1'b0;
    logic        dior_n, diow_n, cyc_done;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    ata_strobe_gen dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_dev(cfg_dev), .cfg_upd(cfg_upd),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_chan(req_chan), .req_dev(req_dev),
        .req_cmd(req_cmd), .req_write(req_write),
        .dior_n(dior_n), .diow_n(diow_n), .cyc_done(cyc_done)
    );

    typedef struct packed {
        logic [31:0] word;
        logic        chan;
        logic        dev;
        logic        cmd;
        logic        wr;
        logic [7:0]  exp_s;
        logic [7:0]  exp_a;
        logic [7:0]  exp_i;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{word: 32'h0000_0000, chan: 1'b0, dev: 1'b0, cmd: 1'b0, wr: 1'b0, exp_s: 8'd1, exp_a: 8'd1,  exp_i: 8'd1},
        '{word: 32'h0080_0053, chan: 1'b0, dev: 1'b1, cmd: 1'b0, wr: 1'b1, exp_s: 8'd3, exp_a: 8'd6,  exp_i: 8'd4},
        '{word: 32'h0200_E8FF, chan: 1'b1, dev: 1'b0, cmd: 1'b1, wr: 1'b0, exp_s: 8'd2, exp_a: 8'd8,  exp_i: 8'd5},
        '{word: 32'h0FFF_FFFF, chan: 1'b1, dev: 1'b1, cmd: 1'b1, wr: 1'b1, exp_s: 8'd8, exp_a: 8'd32, exp_i: 8'd16},
        '{word: 32'h0FFF_FFFF, chan: 1'b1, dev: 1'b1, cmd: 1'b0, wr: 1'b0, exp_s: 8'd8, exp_a: 8'd32, exp_i: 8'd16},
        '{word: 32'h0200_E800, chan: 1'b0, dev: 1'b0, cmd: 1'b0, wr: 1'b0, exp_s: 8'd1, exp_a: 8'd1,  exp_i: 8'd1}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_merge(logic [31:0] old_w, logic [31:0] new_w, logic [1:0] k);
        logic [31:0] m;
        case (k)
            2'd1:    m = 32'hCFC3_FFFF;
            2'd2:    m = 32'h31C0_01FF;
            2'd3:    m = 32'h303C_0000;
            default: m = 32'hFFFF_FFFF;
        endcase
        return (old_w & ~m) | (new_w & m);
    endfunction

    task automatic step();
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_write(input logic c, input logic d, input logic [1:0] k, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = c; cfg_dev = d; cfg_upd = k; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic read_word(input logic c, input logic d, output logic [31:0] w);
        cfg_chan = c; cfg_dev = d;
        #1;
        w = cfg_rdata;
    endtask

    // counts from the current falling edge; returns at the edge where done is seen
    task automatic measure(input logic wr, output int s, output int a, output int i, output bit bad);
        int g = 0;
        s = 0; a = 0; i = 0; bad = 0;
        while (dior_n && diow_n && !cyc_done && g < 300) begin
            s++; step(); g++;
        end
        while ((!dior_n || !diow_n) && g < 300) begin
            a++;
            if (wr ? !dior_n : !diow_n) bad = 1;
            step(); g++;
        end
        while (g < 300) begin
            i++;
            if (!dior_n || !diow_n) bad = 1;
            if (cyc_done) break;
            step(); g++;
        end
    endtask

    task automatic run_cycle(input logic c, input logic d, input logic cmd, input logic wr,
                             input bit mid_en, input logic [31:0] mid_w,
                             output int s, output int a, output int i, output bit bad);
        @(negedge clk);
        req_valid = 1'b1; req_chan = c; req_dev = d; req_cmd = cmd; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        if (mid_en) begin
            cfg_we = 1'b1; cfg_chan = c; cfg_dev = d; cfg_upd = 2'd0; cfg_wdata = mid_w;
        end
        measure(wr, s, a, i, bad);
    endtask

    initial begin
        #(5.0 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] w, expw, keep;
        int s, a, i;
        bit bad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(dior_n && diow_n && !cyc_done, "R1 strobes idle after reset",
            {29'd0, dior_n, diow_n, cyc_done}, 32'h6);
        for (int k = 0; k < 4; k++) begin
            read_word(k[1], k[0], w);
            chk(w == 32'h0, "R1 slot word zero after reset", w, 32'h0);
        end

        // table walk: R4 / R5 / R6 / R7
        for (int v = 0; v < NV; v++) begin
            cfg_write(VECS[v].chan, VECS[v].dev, 2'd0, VECS[v].word);
            read_word(VECS[v].chan, VECS[v].dev, w);
            chk(w == VECS[v].word, "R2 readback after full write", w, VECS[v].word);
            run_cycle(VECS[v].chan, VECS[v].dev, VECS[v].cmd, VECS[v].wr, 1'b0, 32'h0, s, a, i, bad);
            chk(s == int'(VECS[v].exp_s), VECS[v].cmd ? "R5 command setup clocks" : "R4 data setup clocks",
                s, VECS[v].exp_s);
            chk(a == int'(VECS[v].exp_a), VECS[v].cmd ? "R5 command active clocks" : "R4 data active clocks",
                a, VECS[v].exp_a);
            chk(i == int'(VECS[v].exp_i), "R7 inactive clocks ending in done", i, VECS[v].exp_i);
            chk(!bad, "R6 only the matching strobe goes low", bad, 0);
        end

        // R2 slot isolation: chan1/dev0 write must not touch chan0/dev1
        cfg_write(1'b0, 1'b1, 2'd0, 32'h1111_2222);
        cfg_write(1'b1, 1'b0, 2'd0, 32'hDEAD_BEEF);
        read_word(1'b0, 1'b1, w);
        chk(w == 32'h1111_2222, "R2 neighbour slot unchanged", w, 32'h1111_2222);
        read_word(1'b1, 1'b0, w);
        chk(w == 32'hDEAD_BEEF, "R2 addressed slot written", w, 32'hDEAD_BEEF);

        // R3 masked merges
        expw = 32'h1234_5678;
        cfg_write(1'b1, 1'b0, 2'd0, expw);
        cfg_write(1'b1, 1'b0, 2'd1, 32'hFFFF_FFFF);
        expw = exp_merge(expw, 32'hFFFF_FFFF, 2'd1);
        read_word(1'b1, 1'b0, w);
        chk(w == expw, "R3 PIO class merge", w, expw);
        cfg_write(1'b1, 1'b0, 2'd2, 32'h0000_0000);
        expw = exp_merge(expw, 32'h0000_0000, 2'd2);
        read_word(1'b1, 1'b0, w);
        chk(w == expw, "R3 multiword DMA class merge", w, expw);
        cfg_write(1'b1, 1'b0, 2'd3, 32'hFFFF_FFFF);
        expw = exp_merge(expw, 32'hFFFF_FFFF, 2'd3);
        read_word(1'b1, 1'b0, w);
        chk(w == expw, "R3 UDMA class merge", w, expw);

        // R10 no write without enable
        keep = expw;
        @(negedge clk);
        cfg_chan = 1'b1; cfg_dev = 1'b0; cfg_upd = 2'd0; cfg_wdata = 32'h5555_AAAA;
        step(); step();
        read_word(1'b1, 1'b0, w);
        chk(w == keep, "R10 word held without enable", w, keep);

        // R11 mid-cycle write does not alter the running cycle
        cfg_write(1'b0, 1'b1, 2'd0, 32'h0000_0021);
        run_cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00C0_01FF, s, a, i, bad);
        chk(s == 1 && a == 3 && i == 2, "R11 cycle uses word from acceptance",
            {8'd0, s[7:0], a[7:0], i[7:0]}, 32'h0001_0302);
        read_word(1'b0, 1'b1, w);
        chk(w == 32'h00C0_01FF, "R11 mid-cycle write stored", w, 32'h00C0_01FF);

        // R9 back to back: data inact 2, act 3, setup 4; cmd inact 1, act 2, setup 5
        cfg_write(1'b0, 1'b0, 2'd0, 32'h0B00_4232);
        run_cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, s, a, i, bad);
        chk(s == 5 && a == 4 && i == 3, "R4 first data write cycle",
            {8'd0, s[7:0], a[7:0], i[7:0]}, 32'h0005_0403);
        req_valid = 1'b1; req_chan = 1'b0; req_dev = 1'b0; req_cmd = 1'b0; req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!diow_n && dior_n, "R9 same kind strobes in the clock after done",
            {30'd0, dior_n, diow_n}, 32'h2);
        measure(1'b1, s, a, i, bad);
        chk(s == 0 && a == 4 && i == 3 && !bad, "R9 back-to-back skips setup",
            {8'd0, s[7:0], a[7:0], i[7:0]}, 32'h0000_0403);
        req_valid = 1'b1; req_cmd = 1'b1; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        measure(1'b0, s, a, i, bad);
        chk(s == 6 && a == 3 && i == 2 && !bad, "R9 kind change runs setup",
            {8'd0, s[7:0], a[7:0], i[7:0]}, 32'h0006_0302);

        // R8 request during the active phase is ignored
        cfg_write(1'b1, 1'b1, 2'd0, 32'h0000_0070);
        @(negedge clk);
        req_valid = 1'b1; req_chan = 1'b1; req_dev = 1'b1; req_cmd = 1'b0; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        measure(1'b0, s, a, i, bad);
        chk(s == 0 && a == 7 && i == 1 && !bad, "R8 busy request leaves read cycle intact",
            {8'd0, s[7:0], a[7:0], i[7:0]}, 32'h0000_0701);
        bad = 0;
        for (int k = 0; k < 5; k++) begin
            step();
            if (!dior_n || !diow_n || cyc_done) bad = 1;
        end
        chk(!bad, "R8 ignored request starts no cycle", bad, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule